// File: doc/BRIEF.md
# Auto-Incrementing CPU Register Port with Interrupt Control

This block is the processor-facing side of a peripheral. It has one address line and an active-low chip select. With the address line low, the processor reads or writes a 5-bit index. With the address line high, the access goes to whichever of 32 internal byte registers the index selects. After each data access the low nibble of the index advances, so software can walk a run of registers without reloading it. The advance happens only when that nibble was already nonzero, which lets index 0x00 and 0x10 act as fixed windows. Turning on the DMA enable bit returns the index to zero.

The same block gathers five interrupt sources. Each source is a one-cycle event pulse from other logic. The block keeps a sticky status byte, a mask that only gates the interrupt pin, and a write-one-to-clear register that reads back as zero. It also has a chip-reset control bit that stays set for a fixed number of cycles and then clears itself.

Top module: `regport_top`

## Requirements
- R1: A write with `cs_n`=0 and `a0`=0 loads the index from `wdata[4:0]`. A read with `cs_n`=0 and `a0`=0 returns `{3'b000, index}` on `rdata`. `rdata` is 0 when no read is strobed.
- R2: A write with `a0`=1 stores the byte in the register the index selects, and a later read at that index returns it. A read at index 0x01 returns the status in bits 7:3, with bits 2:0 at 0.
- R3: After every data access (`a0`=1, read or write), an index whose low nibble is nonzero advances that nibble by one. The nibble wraps from 0xF to 0x0 and bit 4 keeps its value.
- R4: After a data access, an index whose low nibble is 0 keeps its value.
- R5: A data write to index 0x0A with bit 3 = 1, made while the stored bit 3 is 0, sets the index to 0x00 instead of advancing it. If the stored bit 3 is already 1, the write advances the index normally. The stored bit 3 drives `dma_en_o`.
- R6: A pulse on `evt_i[k]` sets status bit k+3, and the bit stays set. The bits are: bit 7 = ADPCM end (`evt_i[4]`), bit 6 = decoder timeout, bit 5 = DMA complete, bit 4 = decoder event, bit 3 = coding-info error (`evt_i[0]`).
- R7: The mask register is at index 0x04, bits 7:3. It changes only whether a status bit drives the interrupt pin. It never changes the status.
- R8: A data write to index 0x05 clears every status bit whose matching data bit is 1 and leaves the other status bits unchanged. Index 0x05 always reads as 0x00.
- R9: If an event pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R10: `irq_o` is active while any bit of (status AND mask) is 1. It is active-low by default (`IRQ_ACTIVE_LOW`=1).
- R11: Writing bit 4 = 1 to index 0x02 raises `chip_rst_o` for `INIT_CYCLES` cycles after the write edge, then clears it by itself. While it is set, bit 4 of a read at 0x02 is 1.
- R12: After reset the index, status, mask and all registers are 0, `irq_o` is inactive and `chip_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | 0 = index register, 1 = selected data register |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| evt_i | input | 5 | Interrupt event pulses, one cycle wide |
| irq_o | output | 1 | Interrupt pin, polarity set by `IRQ_ACTIVE_LOW` |
| dma_en_o | output | 1 | DMA enable, bit 3 of index 0x0A |
| chip_rst_o | output | 1 | High while chip initialization runs |

## Verification
Two pairs of functions can land in the same cycle.

- **Event and clear.** An event pulse can arrive on the edge where software writes the clear register. The bench drives the pulse and the clear write together, with one bit both set and cleared and another bit only cleared. It then expects the first bit set and the second cleared in the status readback.
- **DMA-enable edge and index advance.** The DMA-enable rising edge and the index advance both come from the same write to index 0x0A. The bench checks that the index reads 0x00 after the enabling write. It also checks that the index reads 0x0B when the bit was already set.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int DW       = 8;
  localparam int IW       = 5;
  localparam int NEVT     = 5;
  localparam int NREG     = 1 << IW;
  localparam int NIB_W    = 4;
  localparam int EVT_LSB  = DW - NEVT;

  localparam logic [IW-1:0] IDX_STATUS  = 5'h01;
  localparam logic [IW-1:0] IDX_CHIPCTL = 5'h02;
  localparam logic [IW-1:0] IDX_MASK    = 5'h04;
  localparam logic [IW-1:0] IDX_CLEAR   = 5'h05;
  localparam logic [IW-1:0] IDX_DMACTL  = 5'h0A;

  localparam int DMA_EN_BIT  = 3;
  localparam int CHIPRST_BIT = 4;

  // Post-access index rule: advance low nibble only if it is nonzero,
  // wrapping inside the nibble; upper bits are kept.
  function automatic logic [IW-1:0] step_index(input logic [IW-1:0] cur);
    logic [NIB_W-1:0] nib;
    nib = cur[NIB_W-1:0];
    if (nib == '0) return cur;
    return {cur[IW-1:NIB_W], nib + NIB_W'(1)};
  endfunction

  // Place the event-bit field inside a data byte.
  function automatic logic [DW-1:0] status_to_byte(input logic [NEVT-1:0] st);
    return {st, {EVT_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/regport_index.sv
module regport_index
  import regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_load,
  input  logic [IW-1:0] load_val,
  input  logic          data_acc,
  input  logic          dma_rise,
  output logic [IW-1:0] idx_q,
  output logic          idx_step
);
  // Named event: the nibble advance actually takes effect this edge.
  assign idx_step = data_acc && !dma_rise && (idx_q[NIB_W-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (dma_rise) begin
      idx_q <= '0;
    end else if (idx_load) begin
      idx_q <= load_val;
    end else if (data_acc) begin
      idx_q <= step_index(idx_q);
    end
  end
endmodule

// File: rtl/regport_regs.sv
module regport_regs
  import regport_pkg::*;
#(
  parameter int INIT_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_word,
  output logic [NEVT-1:0] mask_bits,
  output logic            dma_en,
  output logic            dma_rise,
  output logic            chip_rst
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [DW-1:0] mem_q [NREG];
  logic [CW-1:0] init_cnt_q;
  logic          chip_start;
  logic [DW-1:0] store_val;
  logic [DW-1:0] live_bits;

  assign dma_en     = mem_q[IDX_DMACTL][DMA_EN_BIT];
  assign mask_bits  = mem_q[IDX_MASK][DW-1:EVT_LSB];
  assign dma_rise   = wr_en && (wr_idx == IDX_DMACTL) && wr_data[DMA_EN_BIT] && !dma_en;
  assign chip_start = wr_en && (wr_idx == IDX_CHIPCTL) && wr_data[CHIPRST_BIT];
  assign chip_rst   = (init_cnt_q != '0);

  always_comb begin
    store_val = wr_data;
    if (wr_idx == IDX_CHIPCTL) store_val[CHIPRST_BIT] = 1'b0;
  end

  always_comb begin
    live_bits = '0;
    if (rd_idx == IDX_CHIPCTL) live_bits[CHIPRST_BIT] = chip_rst;
  end

  assign rd_word = mem_q[rd_idx] | live_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (wr_en && (wr_idx != IDX_CLEAR)) begin
      mem_q[wr_idx] <= store_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt_q <= '0;
    end else if (chip_start) begin
      init_cnt_q <= CW'(INIT_CYCLES);
    end else if (init_cnt_q != '0) begin
      init_cnt_q <= init_cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/regport_irq.sv
module regport_irq
  import regport_pkg::*;
#(
  parameter bit IRQ_ACTIVE_LOW = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic            clr_wr,
  input  logic [NEVT-1:0] clr_bits,
  input  logic [NEVT-1:0] mask_bits,
  output logic [NEVT-1:0] status_q,
  output logic            irq_any,
  output logic            irq_pin
);
  logic [NEVT-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;
  assign irq_any = |(status_q & mask_bits);

  generate
    if (IRQ_ACTIVE_LOW) begin : g_low
      assign irq_pin = ~irq_any;
    end else begin : g_high
      assign irq_pin = irq_any;
    end
  endgenerate

  // Set has priority over clear on the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | evt_i;
  end
endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int INIT_CYCLES    = 4,
  parameter bit IRQ_ACTIVE_LOW = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        a0,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [4:0]  evt_i,
  output logic        irq_o,
  output logic        dma_en_o,
  output logic        chip_rst_o
);
  logic            sel;
  logic            idx_wr;
  logic            data_wr;
  logic            data_rd;
  logic            data_acc;
  logic            clr_wr;
  logic            chip_wr;
  logic            dma_rise;
  logic            idx_step;
  logic            irq_any;
  logic [IW-1:0]   idx_q;
  logic [DW-1:0]   reg_word;
  logic [NEVT-1:0] mask_bits;
  logic [NEVT-1:0] status_q;

  assign sel      = !cs_n;
  assign idx_wr   = sel && !a0 && wr_en;
  assign data_wr  = sel && a0 && wr_en;
  assign data_rd  = sel && a0 && rd_en && !wr_en;
  assign data_acc = data_wr || data_rd;
  assign clr_wr   = data_wr && (idx_q == IDX_CLEAR);
  assign chip_wr  = data_wr && (idx_q == IDX_CHIPCTL) && wdata[CHIPRST_BIT];

  regport_index u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (idx_wr),
    .load_val (wdata[IW-1:0]),
    .data_acc (data_acc),
    .dma_rise (dma_rise),
    .idx_q    (idx_q),
    .idx_step (idx_step)
  );

  regport_regs #(.INIT_CYCLES(INIT_CYCLES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (data_wr),
    .wr_idx    (idx_q),
    .wr_data   (wdata),
    .rd_idx    (idx_q),
    .rd_word   (reg_word),
    .mask_bits (mask_bits),
    .dma_en    (dma_en_o),
    .dma_rise  (dma_rise),
    .chip_rst  (chip_rst_o)
  );

  regport_irq #(.IRQ_ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_wr    (clr_wr),
    .clr_bits  (wdata[DW-1:EVT_LSB]),
    .mask_bits (mask_bits),
    .status_q  (status_q),
    .irq_any   (irq_any),
    .irq_pin   (irq_o)
  );

  always_comb begin
    rdata = '0;
    if (sel && rd_en) begin
      if (!a0) begin
        rdata = {{(DW-IW){1'b0}}, idx_q};
      end else begin
        case (idx_q)
          IDX_STATUS: rdata = status_to_byte(status_q);
          IDX_CLEAR:  rdata = '0;
          default:    rdata = reg_word;
        endcase
      end
    end
  end
endmodule

// File: rtl/regport_checker.sv
module regport_checker
  import regport_pkg::*;
#(
  parameter bit IRQ_ACTIVE_LOW = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            data_acc,
  input logic            idx_wr,
  input logic            dma_rise,
  input logic            clr_wr,
  input logic            chip_wr,
  input logic [IW-1:0]   idx_q,
  input logic [DW-1:0]   wdata,
  input logic [NEVT-1:0] evt_i,
  input logic [NEVT-1:0] status_q,
  input logic            irq_o,
  input logic            chip_rst_o
);
  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(wdata[IW-1:0]));

  assert_idx_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !dma_rise && idx_q[NIB_W-1:0] != '0) |=>
      (idx_q[NIB_W-1:0] == $past(idx_q[NIB_W-1:0]) + NIB_W'(1)) &&
      (idx_q[IW-1] == $past(idx_q[IW-1])));

  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !dma_rise && idx_q[NIB_W-1:0] == '0) |=> $stable(idx_q));

  assert_dma_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rise |=> idx_q == '0);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> (status_q & $past(evt_i)) == $past(evt_i));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (status_q & $past(wdata[DW-1:EVT_LSB]) & ~$past(evt_i)) == '0);

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> irq_o == IRQ_ACTIVE_LOW);

  assert_chip_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chip_wr |=> chip_rst_o);
endmodule

bind regport_top regport_checker #(.IRQ_ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_acc   (data_acc),
  .idx_wr     (idx_wr),
  .dma_rise   (dma_rise),
  .clr_wr     (clr_wr),
  .chip_wr    (chip_wr),
  .idx_q      (idx_q),
  .wdata      (wdata),
  .evt_i      (evt_i),
  .status_q   (status_q),
  .irq_o      (irq_o),
  .chip_rst_o (chip_rst_o)
);

// File: tb/regport_top_bench.sv
`timescale 1ns/1ps
module regport_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       a0 = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] evt_i = 5'h00;
  logic       irq_o;
  logic       dma_en_o;
  logic       chip_rst_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic IRQ_OFF = 1'b1;
  localparam logic IRQ_ON  = 1'b0;

  always #4 clk = ~clk;

  regport_top u_regport_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a0(a0), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .evt_i(evt_i),
    .irq_o(irq_o), .dma_en_o(dma_en_o), .chip_rst_o(chip_rst_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; a0 = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00; evt_i = 5'h00;
  endtask

  task automatic wr(input logic addr, input logic [7:0] d, input logic [4:0] ev = 5'h00);
    @(negedge clk);
    cs_n = 1'b0; a0 = addr; wr_en = 1'b1; wdata = d; evt_i = ev;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic addr, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; a0 = addr; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = 5'h00;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v);              check("R12 index after reset", v, 8'h00);
    rd(1'b1, v);              check("R12 reg 0 after reset", v, 8'h00);
    check("R12 irq inactive", {7'h0, irq_o}, {7'h0, IRQ_OFF});
    check("R12 chip_rst low", {7'h0, chip_rst_o}, 8'h00);
    wr(1'b0, 8'h01); rd(1'b1, v);
    check("R12 status zero", v, 8'h00);
  endtask

  task automatic t_index_walk();
    logic [7:0] v;
    wr(1'b0, 8'h13); rd(1'b0, v);
    check("R1 index readback", v, 8'h13);
    wr(1'b0, 8'h0E);
    wr(1'b1, 8'hA5);
    rd(1'b0, v);              check("R3 index advanced to 0F", v, 8'h0F);
    wr(1'b1, 8'h5A);
    rd(1'b0, v);              check("R3 nibble wraps to 00", v, 8'h00);
    wr(1'b0, 8'h1F);
    rd(1'b1, v);
    rd(1'b0, v);              check("R3 bit4 kept on wrap", v, 8'h10);
    rd(1'b1, v); rd(1'b1, v);
    rd(1'b0, v);              check("R4 zero nibble holds", v, 8'h10);
    wr(1'b0, 8'h0E);
    rd(1'b1, v);              check("R2 readback at 0E", v, 8'hA5);
    rd(1'b1, v);              check("R2 readback at 0F", v, 8'h5A);
  endtask

  task automatic t_dma_edge();
    logic [7:0] v;
    wr(1'b0, 8'h0A); wr(1'b1, 8'h08);
    rd(1'b0, v);              check("R5 rising edge clears index", v, 8'h00);
    check("R5 dma_en set", {7'h0, dma_en_o}, 8'h01);
    wr(1'b0, 8'h0A); wr(1'b1, 8'h08);
    rd(1'b0, v);              check("R5 no edge, index advances", v, 8'h0B);
    wr(1'b0, 8'h0A); wr(1'b1, 8'h00);
    check("R5 dma_en cleared", {7'h0, dma_en_o}, 8'h00);
    wr(1'b0, 8'h0A); wr(1'b1, 8'h08);
    rd(1'b0, v);              check("R5 second rising edge", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    pulse(5'b10001);
    wr(1'b0, 8'h01); rd(1'b1, v);
    check("R6 status bits 7 and 3", v, 8'h88);
    check("R7 masked irq inactive", {7'h0, irq_o}, {7'h0, IRQ_OFF});
    wr(1'b0, 8'h04); wr(1'b1, 8'h80);
    check("R10 irq active on mask", {7'h0, irq_o}, {7'h0, IRQ_ON});
    wr(1'b0, 8'h01); rd(1'b1, v);
    check("R7 mask leaves status", v, 8'h88);
    wr(1'b0, 8'h05); wr(1'b1, 8'h80);
    check("R10 irq drops after clear", {7'h0, irq_o}, {7'h0, IRQ_OFF});
    wr(1'b0, 8'h01); rd(1'b1, v);
    check("R8 bit7 cleared, bit3 kept", v, 8'h08);
    wr(1'b0, 8'h05); rd(1'b1, v);
    check("R8 clear register reads 0", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    pulse(5'b10000);
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h88, 5'b00001);
    wr(1'b0, 8'h01); rd(1'b1, v);
    check("R9 set wins over clear", v, 8'h08);
    wr(1'b0, 8'h04); wr(1'b1, 8'h08);
    check("R10 irq on bit3 mask", {7'h0, irq_o}, {7'h0, IRQ_ON});
  endtask

  task automatic t_chip_reset();
    logic [7:0] v;
    wr(1'b0, 8'h02); wr(1'b1, 8'h10);
    check("R11 chip_rst set", {7'h0, chip_rst_o}, 8'h01);
    wr(1'b0, 8'h02); rd(1'b1, v);
    check("R11 readback bit4 while busy", v, 8'h10);
    repeat (6) @(negedge clk);
    check("R11 chip_rst self-clears", {7'h0, chip_rst_o}, 8'h00);
    wr(1'b0, 8'h02); rd(1'b1, v);
    check("R11 readback bit4 clear", v, 8'h00);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index_walk();
    t_dma_edge();
    t_irq();
    t_collide();
    t_chip_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule